// File: doc/BRIEF.md
# Asynchronous Microcontroller Register Port with Word Transfer Handshake

This block lets an external microcontroller with no shared clock reach the internal registers of an FPGA through a small parallel port: a 4-bit address, a 16-bit bidirectional data bus, and active-low read and write strobes. Each strobe passes through a two-flop synchronizer into the system clock. Each strobe causes exactly one register action, taken on the third rising clock edge after the strobe goes low. Everything the firmware does, including moving data, is a read or write of one of sixteen word locations.

Data moves one 16-bit word at a time between the firmware and a host-side word-transfer engine. The firmware sets a transfer-request bit for each word. That bit reads back as set until the host side acknowledges the word. Toward the host, the word comes from a transmit register. From the host, the word lands in a receive register, and a read of that register consumes it. A flag word reports the transfer state and an inbound mailbox. The host side fills the mailbox with a one-cycle pulse, and the firmware clears it.

Top module: `mcu_regport`

## Requirements
- R1: After synchronous reset, the flag word (address 0) reads 0x0000, `dma_req` is low and the data bus is released.
- R2: A write strobe stores the data bus into the addressed register and a read strobe captures the addressed register. Both actions happen once per strobe, on the third rising clock edge after the strobe falls. Scratch (address 5) and transmit (address 2) read back what was written.
- R3: The port drives `mcu_data` only while `mcu_rd_n` is low, with the word captured for that strobe. At all other times the bus is high-impedance.
- R4: Addresses 6 to 15 read as 0x0000, and writes to them change no register.
- R5: Writing address 1 with bit 0 set raises `dma_req` when no transfer is pending. Bit 1 of that write gives the direction (0 = toward host, 1 = from host), shown on `dma_dir`. The pending bit reads as flag bit 0 and as address 1 bit 0, and it stays set until a `dma_ack` pulse. A request written while one is pending is ignored, including its direction bit, which reads as flag bit 3.
- R6: While a toward-host transfer is pending, `dma_wdata` carries the transmit register.
- R7: `dma_ack` during a from-host transfer stores `dma_rdata` in the receive register (address 3) and sets flag bit 1. A read of address 3 with flag bit 1 set returns that word and clears the bit. A read with the bit clear returns 0x0000 and changes nothing.
- R8: A `mbox_set` pulse latches `mbox_word` into address 4 and sets flag bit 2. Writing address 0 with bit 2 set clears flag bit 2.
- R9: Across back-to-back strobes with a four-cycle low time and a three-cycle gap, a multi-word transfer in either direction delivers every word exactly once and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mcu_addr | input | 4 | Register address from the microcontroller |
| mcu_data | inout | 16 | Bidirectional data bus |
| mcu_rd_n | input | 1 | Read strobe, active low |
| mcu_wr_n | input | 1 | Write strobe, active low |
| dma_req | output | 1 | Word transfer pending |
| dma_dir | output | 1 | Transfer direction, 1 = from host |
| dma_wdata | output | 16 | Word offered to the host |
| dma_rdata | input | 16 | Word delivered by the host |
| dma_ack | input | 1 | One-cycle pulse: the word has been moved |
| mbox_set | input | 1 | One-cycle pulse: load the inbound mailbox |
| mbox_word | input | 16 | Mailbox word from the host side |

## Verification
A strobe takes effect on the third rising edge after it falls. The bench therefore holds each strobe low across four falling edges and samples read data at the fourth falling edge. `dma_req` is checked at least one cycle after that third edge. The host model acknowledges two cycles after it sees a request. Busy clears on the edge that samples the acknowledge, so the firmware polls the flag word rather than assuming a fixed latency. Every expected read value goes into a scoreboard queue before the strobe starts. A monitor compares the queued value with the bus at the sampling instant.

// File: rtl/mcu_regport_pkg.sv
package mcu_regport_pkg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 16;

    typedef enum logic [ADDR_W-1:0] {
        RA_FLAGS   = 4'd0,
        RA_CTRL    = 4'd1,
        RA_TX      = 4'd2,
        RA_RX      = 4'd3,
        RA_MBOX    = 4'd4,
        RA_SCRATCH = 4'd5
    } reg_addr_e;

    localparam int FB_BUSY  = 0;
    localparam int FB_RXVAL = 1;
    localparam int FB_MBOX  = 2;
    localparam int FB_DIR   = 3;

    localparam int CB_GO  = 0;
    localparam int CB_DIR = 1;

    typedef struct packed {
        logic busy;
        logic rx_valid;
        logic mbox_full;
        logic dir;
    } flag_state_t;

    function automatic logic [DATA_W-1:0] pack_flags(input flag_state_t f);
        logic [DATA_W-1:0] w;
        w            = '0;
        w[FB_BUSY]   = f.busy;
        w[FB_RXVAL]  = f.rx_valid;
        w[FB_MBOX]   = f.mbox_full;
        w[FB_DIR]    = f.dir;
        return w;
    endfunction

endpackage

// File: rtl/mcu_strobe_sync.sv
module mcu_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_n,
    output logic fire
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-1:0], strobe_n};
    end

    assign fire = chain[STAGES] & ~chain[STAGES-1];

    AST_SINGLE_FIRE: assert property (@(posedge clk) disable iff (rst)
        fire |=> !fire); // R2

endmodule

// File: rtl/mcu_xfer_ctrl.sv
module mcu_xfer_ctrl
    import mcu_regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go_wr,
    input  logic              dir_in,
    input  logic              rx_pop,
    input  logic              dma_ack,
    input  logic [DATA_W-1:0] dma_rdata,
    output logic              busy,
    output logic              dir,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_word
);
    logic done;
    assign done = busy & dma_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            dir      <= 1'b0;
            rx_valid <= 1'b0;
            rx_word  <= '0;
        end else begin
            if (done) begin
                busy <= 1'b0;
            end else if (go_wr && !busy) begin
                busy <= 1'b1;
                dir  <= dir_in;
            end
            if (done && dir) begin
                rx_word  <= dma_rdata;
                rx_valid <= 1'b1;
            end else if (rx_pop) begin
                rx_valid <= 1'b0;
            end
        end
    end

    AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
        busy && !dma_ack |=> busy); // R5
    AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (rst)
        busy && dma_ack |=> !busy); // R5
    AST_DIR_STABLE: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(dir)); // R5
    AST_EMPTY_NO_POP: assert property (@(posedge clk) disable iff (rst)
        !rx_valid && !(done && dir) |=> !rx_valid); // R7

endmodule

// File: rtl/mcu_mailbox.sv
module mcu_mailbox
    import mcu_regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              set,
    input  logic [DATA_W-1:0] word_in,
    input  logic              clr,
    output logic              full,
    output logic [DATA_W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            word <= '0;
        end else if (set) begin
            full <= 1'b1;
            word <= word_in;
        end else if (clr) begin
            full <= 1'b0;
        end
    end

    AST_MBOX_LOADS: assert property (@(posedge clk) disable iff (rst)
        set |=> full); // R8

endmodule

// File: rtl/mcu_regport.sv
module mcu_regport
    import mcu_regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] mcu_addr,
    inout  wire  [DATA_W-1:0] mcu_data,
    input  logic              mcu_rd_n,
    input  logic              mcu_wr_n,
    output logic              dma_req,
    output logic              dma_dir,
    output logic [DATA_W-1:0] dma_wdata,
    input  logic [DATA_W-1:0] dma_rdata,
    input  logic              dma_ack,
    input  logic              mbox_set,
    input  logic [DATA_W-1:0] mbox_word
);
    localparam int N_STROBES = 2;

    logic [N_STROBES-1:0] strobes_n;
    logic [N_STROBES-1:0] fires;
    logic                 fire_rd, fire_wr;

    assign strobes_n = {mcu_wr_n, mcu_rd_n};

    for (genvar g = 0; g < N_STROBES; g++) begin : g_sync
        mcu_strobe_sync #(.STAGES(2)) u_sync (
            .clk      (clk),
            .rst      (rst),
            .strobe_n (strobes_n[g]),
            .fire     (fires[g])
        );
    end

    assign fire_rd = fires[0];
    assign fire_wr = fires[1];

    logic [DATA_W-1:0] tx_reg, scratch_reg, rd_hold;
    logic              busy, dir, rx_valid, mbox_full;
    logic [DATA_W-1:0] rx_word, mbox_reg;
    logic              go_wr, rx_pop, mbox_clr;
    flag_state_t       flags;

    assign go_wr    = fire_wr && (mcu_addr == RA_CTRL) && mcu_data[CB_GO];
    assign mbox_clr = fire_wr && (mcu_addr == RA_FLAGS) && mcu_data[FB_MBOX];
    assign rx_pop   = fire_rd && (mcu_addr == RA_RX) && rx_valid;

    mcu_xfer_ctrl u_xfer (
        .clk       (clk),
        .rst       (rst),
        .go_wr     (go_wr),
        .dir_in    (mcu_data[CB_DIR]),
        .rx_pop    (rx_pop),
        .dma_ack   (dma_ack),
        .dma_rdata (dma_rdata),
        .busy      (busy),
        .dir       (dir),
        .rx_valid  (rx_valid),
        .rx_word   (rx_word)
    );

    mcu_mailbox u_mbox (
        .clk     (clk),
        .rst     (rst),
        .set     (mbox_set),
        .word_in (mbox_word),
        .clr     (mbox_clr),
        .full    (mbox_full),
        .word    (mbox_reg)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_reg      <= '0;
            scratch_reg <= '0;
        end else if (fire_wr) begin
            case (mcu_addr)
                RA_TX:      tx_reg      <= mcu_data;
                RA_SCRATCH: scratch_reg <= mcu_data;
                default:    ;
            endcase
        end
    end

    always_comb begin
        flags.busy      = busy;
        flags.rx_valid  = rx_valid;
        flags.mbox_full = mbox_full;
        flags.dir       = dir;
    end

    logic [DATA_W-1:0] rd_mux;
    always_comb begin
        rd_mux = '0;
        case (mcu_addr)
            RA_FLAGS:   rd_mux = pack_flags(flags);
            RA_CTRL: begin
                rd_mux[CB_GO]  = busy;
                rd_mux[CB_DIR] = dir;
            end
            RA_TX:      rd_mux = tx_reg;
            RA_RX:      rd_mux = rx_valid ? rx_word : '0;
            RA_MBOX:    rd_mux = mbox_reg;
            RA_SCRATCH: rd_mux = scratch_reg;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)          rd_hold <= '0;
        else if (fire_rd) rd_hold <= rd_mux;
    end

    assign mcu_data  = mcu_rd_n ? {DATA_W{1'bz}} : rd_hold;
    assign dma_req   = busy;
    assign dma_dir   = dir;
    assign dma_wdata = tx_reg;

    AST_WRITE_NEEDS_LOW: assert property (@(posedge clk) disable iff (rst)
        fire_wr |-> !mcu_wr_n); // R2

endmodule

// File: tb/mcu_regport_bench.sv
module mcu_regport_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  addr = '0;
    logic        rd_n = 1'b1, wr_n = 1'b1;
    logic [15:0] drv = '0;
    logic        oe = 1'b0;
    tri1  [15:0] bus;
    logic        dma_req, dma_dir, dma_ack = 1'b0;
    logic [15:0] dma_wdata, dma_rdata = '0;
    logic        mbox_set = 1'b0;
    logic [15:0] mbox_word = '0;

    assign bus = oe ? drv : 16'bz;

    always #4 clk = ~clk;

    mcu_regport u_mcu_regport (
        .clk(clk), .rst(rst), .mcu_addr(addr), .mcu_data(bus),
        .mcu_rd_n(rd_n), .mcu_wr_n(wr_n), .dma_req(dma_req),
        .dma_dir(dma_dir), .dma_wdata(dma_wdata), .dma_rdata(dma_rdata),
        .dma_ack(dma_ack), .mbox_set(mbox_set), .mbox_word(mbox_word)
    );

    int checks = 0, errors = 0;

    typedef struct { logic [15:0] exp; string tag; } exp_t;
    exp_t        sb_q[$];
    logic [15:0] sink[$];
    logic [15:0] host_next = 16'h7000;
    bit          host_en = 1'b1;
    event        smp;

    task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // host-side transfer engine model
    initial begin
        int wait_cnt = 0;
        forever begin
            @(negedge clk);
            dma_ack = 1'b0;
            if (dma_req && host_en) begin
                wait_cnt++;
                if (wait_cnt == 2) begin
                    wait_cnt = 0;
                    dma_ack  = 1'b1;
                    if (dma_dir) begin
                        dma_rdata = host_next;
                        host_next = host_next + 16'd1;
                    end else begin
                        sink.push_back(dma_wdata);
                    end
                end
            end else begin
                wait_cnt = 0;
            end
        end
    end

    // scoreboard monitor
    initial begin
        forever begin
            @(smp);
            if (sb_q.size() == 0) begin
                chk(1'b0, "scoreboard-underflow", bus, 16'h0);
            end else begin
                exp_t it;
                it = sb_q.pop_front();
                chk(bus === it.exp, it.tag, bus, it.exp);
            end
        end
    end

    task automatic mcu_wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; drv = d; oe = 1'b1; wr_n = 1'b0;
        repeat (4) @(negedge clk);
        wr_n = 1'b1; oe = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic mcu_rd(input logic [3:0] a, input bit scored, output logic [15:0] v);
        @(negedge clk);
        addr = a; rd_n = 1'b0;
        repeat (4) @(negedge clk);
        v = bus;
        if (scored) -> smp;
        #1;
        rd_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic rd_expect(input logic [3:0] a, input logic [15:0] e, input string tag);
        logic [15:0] v;
        exp_t it;
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        mcu_rd(a, 1'b1, v);
    endtask

    task automatic wait_idle();
        logic [15:0] v;
        for (int i = 0; i < 50; i++) begin
            mcu_rd(4'd0, 1'b0, v);
            if (!v[0]) break;
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(dma_req == 1'b0, "R1 dma_req after reset", {15'b0, dma_req}, 16'h0);
        chk(bus === 16'hFFFF, "R1 R3 bus released after reset", bus, 16'hFFFF);
        rd_expect(4'd0, 16'h0000, "R1 flags after reset");

        // R2 register write/read
        mcu_wr(4'd5, 16'hA5A5);
        rd_expect(4'd5, 16'hA5A5, "R2 scratch A5A5");
        mcu_wr(4'd5, 16'h1234);
        rd_expect(4'd5, 16'h1234, "R2 scratch 1234");
        mcu_wr(4'd2, 16'hBEEF);
        rd_expect(4'd2, 16'hBEEF, "R2 tx readback");
        chk(bus === 16'hFFFF, "R3 bus released after read", bus, 16'hFFFF);

        // R4 unassigned addresses
        mcu_wr(4'd9, 16'hFFFF);
        rd_expect(4'd9, 16'h0000, "R4 addr 9 reads zero");
        mcu_wr(4'd15, 16'h5555);
        rd_expect(4'd15, 16'h0000, "R4 addr 15 reads zero");
        rd_expect(4'd5, 16'h1234, "R4 scratch untouched");
        rd_expect(4'd2, 16'hBEEF, "R4 tx untouched");

        // R5 / R6 request holds, second request ignored
        host_en = 1'b0;
        mcu_wr(4'd2, 16'hCAFE);
        mcu_wr(4'd1, 16'h0001);
        chk(dma_req == 1'b1, "R5 dma_req raised", {15'b0, dma_req}, 16'h1);
        chk(dma_dir == 1'b0, "R5 dma_dir toward host", {15'b0, dma_dir}, 16'h0);
        chk(dma_wdata == 16'hCAFE, "R6 dma_wdata is tx", dma_wdata, 16'hCAFE);
        rd_expect(4'd0, 16'h0001, "R5 flags pending");
        mcu_wr(4'd1, 16'h0003);
        rd_expect(4'd0, 16'h0001, "R5 second request ignored");
        rd_expect(4'd1, 16'h0001, "R5 ctrl readback pending");
        host_en = 1'b1;
        repeat (8) @(negedge clk);
        chk(dma_req == 1'b0, "R5 request cleared by ack", {15'b0, dma_req}, 16'h0);
        rd_expect(4'd0, 16'h0000, "R5 flags idle after ack");
        chk(sink.size() == 1 && sink[0] == 16'hCAFE, "R6 host got CAFE",
            sink.size() > 0 ? sink[0] : 16'h0, 16'hCAFE);

        // R7 empty read, then from-host word
        rd_expect(4'd3, 16'h0000, "R7 empty rx reads zero");
        rd_expect(4'd0, 16'h0000, "R7 empty read no state change");
        mcu_wr(4'd1, 16'h0003);
        wait_idle();
        rd_expect(4'd0, 16'h000A, "R7 rx valid flag");
        rd_expect(4'd3, 16'h7000, "R7 rx word");
        rd_expect(4'd3, 16'h0000, "R7 second read empty");
        rd_expect(4'd0, 16'h0008, "R7 valid cleared");

        // R8 mailbox
        @(negedge clk);
        mbox_word = 16'h55AA; mbox_set = 1'b1;
        @(negedge clk);
        mbox_set = 1'b0; mbox_word = 16'h0;
        rd_expect(4'd0, 16'h000C, "R8 mailbox flag set");
        rd_expect(4'd4, 16'h55AA, "R8 mailbox word");
        mcu_wr(4'd0, 16'h0004);
        rd_expect(4'd0, 16'h0008, "R8 mailbox flag cleared");

        // R9 multi-word toward host
        for (int k = 0; k < 6; k++) begin
            mcu_wr(4'd2, 16'h0100 + 16'(k));
            mcu_wr(4'd1, 16'h0001);
            wait_idle();
        end
        chk(sink.size() == 7, "R9 toward-host word count", 16'(sink.size()), 16'd7);
        for (int k = 0; k < 6; k++) begin
            logic [15:0] got;
            got = (k + 1 < sink.size()) ? sink[k+1] : 16'hDEAD;
            chk(got == 16'h0100 + 16'(k), "R9 toward-host order", got, 16'h0100 + 16'(k));
        end

        // R9 multi-word from host
        for (int k = 0; k < 6; k++) begin
            mcu_wr(4'd1, 16'h0003);
            wait_idle();
            rd_expect(4'd3, 16'h7001 + 16'(k), "R9 from-host word");
        end
        rd_expect(4'd3, 16'h0000, "R9 no extra word");

        repeat (4) @(negedge clk);
        chk(sb_q.size() == 0, "R9 scoreboard drained", 16'(sb_q.size()), 16'h0);
        summary();
        $finish;
    end

endmodule